// File: doc/BRIEF.md
# Byte memory with hidden per-byte bits

This block is a byte-addressed RAM in which every visible byte owns one extra bit that ordinary reads never show. The extra bits live in a separate store of 2-bit entries: entry `addr >> 1` holds the bits of the even byte (entry bit 1) and the odd byte (entry bit 0) of that pair. A write of 1, 2, 4 or 8 bytes updates the visible bytes. How it touches the hidden bits depends on the access size and, for single bytes, on whether the address is odd or even. When the test-mode input accompanies a read, the read returns a 4-bit window of hidden bits instead of memory data.

Capacity is a base byte count, doubled when the expansion parameter is set. A cold reset starts a sweep that zeroes one 8-byte row of visible data and the four matching hidden entries per cycle. A warm reset leaves both stores untouched. Accesses are naturally aligned: the low address bits below the access size are ignored. Data on both buses is right-aligned and big-endian, so the lowest-addressed byte is the most significant byte of the access.

Top module: `bhp_mem`

## Requirements
- R1: `cold_rst` raises `clr_busy` on the next edge. After `cold_rst` is released, `clr_busy` stays high for exactly ROWS = capacity/8 cycles. Once it falls, every visible byte and every hidden bit reads as zero.
- R2: `rst` clears only `rd_valid` and `rd_data`, and drops requests while it is high. Visible and hidden contents written before a warm reset read back unchanged after it.
- R3: The access size code is 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8 bytes. The address is aligned down to the size. Data is right-aligned in the 64-bit bus, and the byte at the lowest address sits in the most significant position. Unused upper read bits are zero.
- R4: A 1-byte write to an odd address sets that byte's hidden bit to bit 0 of the data. A 1-byte write to an even address clears that byte's hidden bit.
- R5: A 2-byte write sets the hidden bits of both of its bytes to bit 0 of the written halfword (`wr_data[0]`).
- R6: A 4-byte or 8-byte write changes only visible bytes and leaves every hidden bit as it was.
- R7: A read with `test_mode` high at raw address A returns, in `rd_data[3:0]`, the entry at A>>1 in bits [3:2] and the entry at (A>>1)+1 in bits [1:0]. An entry past the last one reads as 00, and bits [63:4] are zero. `rd_size` is ignored.
- R8: A write whose aligned address is at or above capacity changes nothing. A read at or above capacity (aligned address in normal mode, raw address in test mode) returns zero with `rd_valid` high.
- R9: A read accepted on one edge presents `rd_valid` = 1 and its data after that edge and is zero/low otherwise. A read and a write in the same cycle return the contents as they were before the write.
- R10: While `clr_busy` is high, writes are dropped and reads produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| cold_rst | input | 1 | Cold reset, starts the clearing sweep |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write byte address |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data, right-aligned, big-endian |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | 2 | Read size code |
| test_mode | input | 1 | Return hidden bits for this read |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Read result |
| clr_busy | output | 1 | Cold clearing sweep in progress |

## Verification
The bench builds the block with a 256-byte base, expansion on and a 10-bit address. This gives 512 bytes in 64 rows, so the whole cold sweep fits in a few dozen cycles and can be run twice. The address range reaches up to twice the capacity, so out-of-range writes are tried whose truncated row index would alias low rows if they were not blocked. The last hidden entry is small enough to reach directly, which exercises the test-mode window that runs past the end of the store.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DUAL = 2'd3
    } xfer_size_e;

    localparam int unsigned LANES  = 8;
    localparam int unsigned BUS_W  = 64;

    // Visible row update: byte enables and row-positioned data.
    typedef struct packed {
        logic [LANES-1:0] be;
        logic [BUS_W-1:0] data;
    } vis_wr_t;

    // Hidden entry update: which of the two bits change and their values.
    typedef struct packed {
        logic [1:0] mask;
        logic [1:0] val;
    } hid_wr_t;

    function automatic logic [3:0] size_bytes(input xfer_size_e s);
        unique case (s)
            SZ_BYTE: return 4'd1;
            SZ_HALF: return 4'd2;
            SZ_WORD: return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input xfer_size_e s);
        unique case (s)
            SZ_BYTE: return 8'h01;
            SZ_HALF: return 8'h03;
            SZ_WORD: return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] bit_mask(input xfer_size_e s);
        unique case (s)
            SZ_BYTE: return 64'h0000_0000_0000_00FF;
            SZ_HALF: return 64'h0000_0000_0000_FFFF;
            SZ_WORD: return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Clears the low address bits below the access size.
    function automatic logic [2:0] align_low(input logic [2:0] lo, input xfer_size_e s);
        unique case (s)
            SZ_BYTE: return lo;
            SZ_HALF: return {lo[2:1], 1'b0};
            SZ_WORD: return {lo[2], 2'b00};
            default: return 3'b000;
        endcase
    endfunction

    // Byte distance between the access's last byte and the row's last byte.
    function automatic logic [2:0] lane_shift(input logic [2:0] off, input xfer_size_e s);
        return 3'(4'd8 - ({1'b0, off} + size_bytes(s)));
    endfunction

    // Hidden-bit rule by size and address parity.
    function automatic hid_wr_t hid_rule(input xfer_size_e s, input logic odd, input logic d0);
        hid_wr_t r;
        unique case (s)
            SZ_BYTE: begin
                r.mask = odd ? 2'b01 : 2'b10;
                r.val  = odd ? {1'b0, d0} : 2'b00;
            end
            SZ_HALF: begin
                r.mask = 2'b11;
                r.val  = {d0, d0};
            end
            default: begin
                r.mask = 2'b00;
                r.val  = 2'b00;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bhp_clear_seq.sv
module bhp_clear_seq #(
    parameter int unsigned ROWS  = 128,
    parameter int unsigned ROW_W = 7
) (
    input  logic             clk,
    input  logic             cold_rst,
    output logic             busy,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            busy <= 1'b1;
            row  <= '0;
        end else if (busy) begin
            if (row == LAST_ROW) begin
                busy <= 1'b0;
            end else begin
                row <= row + ROW_W'(1);
            end
        end
    end

endmodule

// File: rtl/bhp_write_decode.sv
module bhp_write_decode
    import bhp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned CAP_BYTES = 1024,
    parameter int unsigned ROW_W     = 7,
    parameter int unsigned HIDX_W    = 9
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_raw,
    input  logic [BUS_W-1:0]  data,
    output logic              vis_we,
    output logic [ROW_W-1:0]  vis_row,
    output vis_wr_t           vis_wr,
    output logic              hid_we,
    output logic [HIDX_W-1:0] hid_idx,
    output hid_wr_t           hid_wr
);

    localparam logic [ADDR_W:0] CAP_L = (ADDR_W+1)'(CAP_BYTES);

    xfer_size_e        sz;
    logic [2:0]        lo;
    logic [ADDR_W:0]   a_ext;
    logic              in_range;
    logic [2:0]        sh;

    always_comb begin
        sz       = xfer_size_e'(size_raw);
        lo       = align_low(addr[2:0], sz);
        a_ext    = {1'b0, addr[ADDR_W-1:3], lo};
        in_range = (a_ext < CAP_L);
        sh       = lane_shift(lo, sz);

        vis_we      = en && in_range;
        vis_row     = ROW_W'(a_ext >> 3);
        vis_wr.be   = lane_mask(sz) << sh;
        vis_wr.data = data << {sh, 3'b000};

        hid_wr  = hid_rule(sz, lo[0], data[0]);
        hid_idx = HIDX_W'(a_ext >> 1);
        hid_we  = en && in_range && (hid_wr.mask != 2'b00);
    end

endmodule

// File: rtl/bhp_vis_store.sv
module bhp_vis_store
    import bhp_pkg::*;
#(
    parameter int unsigned ROWS  = 128,
    parameter int unsigned ROW_W = 7
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [ROW_W-1:0] clr_row,
    input  logic             we,
    input  logic [ROW_W-1:0] wrow,
    input  vis_wr_t          wr,
    input  logic [ROW_W-1:0] rrow,
    output logic [BUS_W-1:0] rdata
);

    logic [BUS_W-1:0] mem [ROWS];
    logic [BUS_W-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = wr.be[g] ? wr.data[8*g +: 8] : mem[wrow][8*g +: 8];
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_row] <= '0;
        end else if (we) begin
            mem[wrow] <= merged;
        end
    end

    assign rdata = mem[rrow];

endmodule

// File: rtl/bhp_hid_store.sv
module bhp_hid_store
    import bhp_pkg::*;
#(
    parameter int unsigned ROW_W  = 7,
    parameter int unsigned HIDX_W = 9
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [ROW_W-1:0]  clr_row,
    input  logic              we,
    input  logic [HIDX_W-1:0] widx,
    input  hid_wr_t           wr,
    input  logic [HIDX_W-1:0] ridx_a,
    input  logic [HIDX_W-1:0] ridx_b,
    output logic [1:0]        rd_a,
    output logic [1:0]        rd_b
);

    localparam int unsigned ENTRIES      = 1 << HIDX_W;
    localparam int unsigned ENT_PER_ROW  = 4;

    logic [1:0] hmem [ENTRIES];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            for (int k = 0; k < ENT_PER_ROW; k++) begin
                hmem[{clr_row, 2'(k)}] <= 2'b00;
            end
        end else if (we) begin
            hmem[widx] <= (hmem[widx] & ~wr.mask) | (wr.val & wr.mask);
        end
    end

    assign rd_a = hmem[ridx_a];
    assign rd_b = hmem[ridx_b];

endmodule

// File: rtl/bhp_read_format.sv
module bhp_read_format
    import bhp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned CAP_BYTES = 1024,
    parameter int unsigned ROW_W     = 7,
    parameter int unsigned HIDX_W    = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_raw,
    input  logic              test,
    input  logic [BUS_W-1:0]  row_data,
    input  logic [1:0]        hid_a,
    input  logic [1:0]        hid_b,
    output logic [ROW_W-1:0]  rrow,
    output logic [HIDX_W-1:0] hidx_a,
    output logic [HIDX_W-1:0] hidx_b,
    output logic [BUS_W-1:0]  fmt_data
);

    localparam logic [ADDR_W:0] CAP_L = (ADDR_W+1)'(CAP_BYTES);

    xfer_size_e       sz;
    logic [2:0]       lo;
    logic [ADDR_W:0]  a_ext;
    logic             in_norm;
    logic             in_test;
    logic             b_ok;
    logic [BUS_W-1:0] norm_val;
    logic [BUS_W-1:0] test_val;

    always_comb begin
        sz      = xfer_size_e'(size_raw);
        lo      = align_low(addr[2:0], sz);
        a_ext   = {1'b0, addr[ADDR_W-1:3], lo};
        in_norm = (a_ext < CAP_L);
        in_test = ({1'b0, addr} < CAP_L);

        rrow    = ROW_W'(addr >> 3);
        hidx_a  = HIDX_W'(addr >> 1);
        hidx_b  = hidx_a + HIDX_W'(1);
        b_ok    = ~&hidx_a;

        norm_val = (row_data >> {lane_shift(lo, sz), 3'b000}) & bit_mask(sz);
        test_val = {60'b0, hid_a, (b_ok ? hid_b : 2'b00)};

        if (test) begin
            fmt_data = in_test ? test_val : '0;
        end else begin
            fmt_data = in_norm ? norm_val : '0;
        end
    end

endmodule

// File: rtl/bhp_mem.sv
module bhp_mem
    import bhp_pkg::*;
#(
    parameter int unsigned BASE_BYTES = 1024,
    parameter bit          EXPANSION  = 1'b0,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cold_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [63:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    input  logic              test_mode,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              clr_busy
);

    localparam int unsigned CAP_BYTES = EXPANSION ? 2 * BASE_BYTES : BASE_BYTES;
    localparam int unsigned ROWS      = CAP_BYTES / LANES;
    localparam int unsigned ROW_W     = $clog2(ROWS);
    localparam int unsigned HIDX_W    = ROW_W + 2;

    logic              rd_go;
    logic              wr_go;
    logic [ROW_W-1:0]  clr_row;

    logic              vis_we;
    logic [ROW_W-1:0]  vis_wrow;
    vis_wr_t           vis_wr;
    logic              hid_we;
    logic [HIDX_W-1:0] hid_widx;
    hid_wr_t           hid_wr;

    logic [ROW_W-1:0]  rrow;
    logic [HIDX_W-1:0] hidx_a;
    logic [HIDX_W-1:0] hidx_b;
    logic [BUS_W-1:0]  row_data;
    logic [1:0]        hid_a;
    logic [1:0]        hid_b;
    logic [BUS_W-1:0]  fmt_data;

    assign rd_go = rd_en && !clr_busy && !rst && !cold_rst;
    assign wr_go = wr_en && !clr_busy && !rst && !cold_rst;

    bhp_clear_seq #(.ROWS(ROWS), .ROW_W(ROW_W)) u_clear (
        .clk      (clk),
        .cold_rst (cold_rst),
        .busy     (clr_busy),
        .row      (clr_row)
    );

    bhp_write_decode #(
        .ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES), .ROW_W(ROW_W), .HIDX_W(HIDX_W)
    ) u_wdec (
        .en       (wr_go),
        .addr     (wr_addr),
        .size_raw (wr_size),
        .data     (wr_data),
        .vis_we   (vis_we),
        .vis_row  (vis_wrow),
        .vis_wr   (vis_wr),
        .hid_we   (hid_we),
        .hid_idx  (hid_widx),
        .hid_wr   (hid_wr)
    );

    bhp_vis_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_vis (
        .clk      (clk),
        .clr_en   (clr_busy),
        .clr_row  (clr_row),
        .we       (vis_we),
        .wrow     (vis_wrow),
        .wr       (vis_wr),
        .rrow     (rrow),
        .rdata    (row_data)
    );

    bhp_hid_store #(.ROW_W(ROW_W), .HIDX_W(HIDX_W)) u_hid (
        .clk      (clk),
        .clr_en   (clr_busy),
        .clr_row  (clr_row),
        .we       (hid_we),
        .widx     (hid_widx),
        .wr       (hid_wr),
        .ridx_a   (hidx_a),
        .ridx_b   (hidx_b),
        .rd_a     (hid_a),
        .rd_b     (hid_b)
    );

    bhp_read_format #(
        .ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES), .ROW_W(ROW_W), .HIDX_W(HIDX_W)
    ) u_rfmt (
        .addr     (rd_addr),
        .size_raw (rd_size),
        .test     (test_mode),
        .row_data (row_data),
        .hid_a    (hid_a),
        .hid_b    (hid_b),
        .rrow     (rrow),
        .hidx_a   (hidx_a),
        .hidx_b   (hidx_b),
        .fmt_data (fmt_data)
    );

    always_ff @(posedge clk) begin
        if (rst || cold_rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            rd_data  <= rd_go ? fmt_data : '0;
        end
    end

endmodule

// File: rtl/bhp_mem_chk.sv
module bhp_mem_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned CAP_BYTES = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              cold_rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [1:0]        rd_size,
    input logic              test_mode,
    input logic              rd_valid,
    input logic [63:0]       rd_data,
    input logic              clr_busy
);

    localparam logic [ADDR_W:0] CAP_L = (ADDR_W+1)'(CAP_BYTES);

    logic accept;
    assign accept = rd_en && !clr_busy && !cold_rst;

    assert_busy_after_cold_R1: assert property (@(posedge clk) disable iff (rst)
        cold_rst |=> clr_busy);

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> rd_valid);

    assert_no_read_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && clr_busy) |=> !rd_valid);

    assert_test_window_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && test_mode) |=> (rd_data[63:4] == 60'b0));

    assert_out_of_range_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && ({1'b0, rd_addr} >= CAP_L)) |=> (rd_data == 64'b0));

    assert_byte_read_width_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !test_mode && (rd_size == 2'd0)) |=> (rd_data[63:8] == 56'b0));

endmodule

bind bhp_mem bhp_mem_chk #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cold_rst  (cold_rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_size   (rd_size),
    .test_mode (test_mode),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .clr_busy  (clr_busy)
);

// File: tb/bhp_mem_test.sv
module bhp_mem_test;

    localparam int unsigned BASE   = 256;
    localparam bit          EXPAND = 1'b1;
    localparam int unsigned ADDR_W = 10;
    localparam int          CAP    = EXPAND ? 2 * BASE : BASE;
    localparam int          ROWS   = CAP / 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              cold_rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        wr_size;
    logic [63:0]       wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [1:0]        rd_size;
    logic              test_mode;
    logic              rd_valid;
    logic [63:0]       rd_data;
    logic              clr_busy;

    always #10 clk = ~clk;

    bhp_mem #(.BASE_BYTES(BASE), .EXPANSION(EXPAND), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .cold_rst(cold_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size), .test_mode(test_mode),
        .rd_valid(rd_valid), .rd_data(rd_data), .clr_busy(clr_busy)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    bit    started = 0;
    string cur_req = "";

    // Behavioural reference: one byte and one hidden bit per address.
    logic [7:0]  m_vis [CAP];
    logic        m_hid [CAP];
    int          m_left = 0;
    logic        m_valid = 1'b0;
    logic [63:0] m_data = '0;
    string       m_tag = "R9";

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input int unsigned addr, input int sz, input bit test);
        int          n;
        int unsigned a;
        int unsigned b;
        logic [63:0] r;
        r = '0;
        if (test) begin
            if (addr >= CAP) return '0;
            b = addr & ~32'd1;
            r[3] = m_hid[b];
            r[2] = m_hid[b + 1];
            r[1] = (b + 2 < CAP) ? m_hid[b + 2] : 1'b0;
            r[0] = (b + 3 < CAP) ? m_hid[b + 3] : 1'b0;
            return r;
        end
        n = 1 << sz;
        a = addr & ~(n - 1);
        if (a >= CAP) return '0;
        for (int i = 0; i < n; i++) r = (r << 8) | 64'(m_vis[a + i]);
        return r;
    endfunction

    task automatic model_write(input int unsigned addr, input int sz, input logic [63:0] d);
        int          n;
        int unsigned a;
        n = 1 << sz;
        a = addr & ~(n - 1);
        if (a >= CAP) return;
        for (int i = 0; i < n; i++) m_vis[a + i] = d[8*(n-1-i) +: 8];
        if (sz == 0) m_hid[a] = a[0] ? d[0] : 1'b0;
        else if (sz == 1) begin
            m_hid[a]     = d[0];
            m_hid[a + 1] = d[0];
        end
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst || cold_rst || m_left > 0 || !rd_en) begin
            m_valid = 1'b0;
            m_data  = '0;
        end else begin
            m_valid = 1'b1;
            m_data  = model_read(rd_addr, int'(rd_size), test_mode);
            if (cur_req != "") m_tag = cur_req;
            else if (test_mode) m_tag = "R7";
            else if (rd_addr >= CAP) m_tag = "R8";
            else m_tag = "R3";
        end
        if (!rst && !cold_rst && wr_en && m_left == 0)
            model_write(wr_addr, int'(wr_size), wr_data);
        if (cold_rst) begin
            for (int i = 0; i < CAP; i++) begin
                m_vis[i] = 8'h00;
                m_hid[i] = 1'b0;
            end
            m_left = ROWS;
        end else if (m_left > 0) begin
            m_left = m_left - 1;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(clr_busy === (m_left > 0), "R1", 64'(clr_busy), 64'(m_left > 0));
            chk(rd_valid === m_valid, (rst || cold_rst) ? "R2" : (m_left > 0 ? "R10" : "R9"),
                64'(rd_valid), 64'(m_valid));
            chk(rd_data === m_data, m_valid ? m_tag : "R9", rd_data, m_data);
        end
    end

    task automatic put_wr(input int unsigned a, input int s, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_size = 2'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_rd(input int unsigned a, input int s, input bit t, input string req);
        cur_req = req;
        rd_en = 1'b1; rd_addr = ADDR_W'(a); rd_size = 2'(s); test_mode = t;
        @(negedge clk);
        rd_en = 1'b0; test_mode = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int cnt;
        rst = 1'b1; cold_rst = 1'b1;
        wr_en = 0; wr_addr = '0; wr_size = '0; wr_data = '0;
        rd_en = 0; rd_addr = '0; rd_size = '0; test_mode = 0;
        repeat (3) @(negedge clk);
        // R2: reset state of the read outputs
        chk(rd_valid === 1'b0 && rd_data === 64'b0, "R2", rd_data, 64'b0);

        // R1/R10: release, try a write and a read during the sweep, count busy cycles
        rst = 1'b0; cold_rst = 1'b0;
        wr_en = 1'b1; wr_addr = ADDR_W'(16); wr_size = 2'd3; wr_data = '1;
        rd_en = 1'b1; rd_addr = ADDR_W'(16); rd_size = 2'd3;
        cnt = 0;
        while (clr_busy) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            cnt++;
        end
        chk(cnt == ROWS, "R1", 64'(cnt), 64'(ROWS));
        put_rd(16, 3, 0, "R10");
        put_rd(0, 3, 0, "R1");
        put_rd(CAP - 8, 3, 0, "R1");
        put_rd(100, 0, 1, "R1");

        // R3: big-endian layout and alignment
        put_wr(8, 3, 64'h0011_2233_4455_6677);
        put_rd(8, 0, 0, "R3");
        put_rd(9, 0, 0, "R3");
        put_rd(11, 1, 0, "R3");
        put_rd(13, 2, 0, "R3");
        put_rd(15, 3, 0, "R3");
        put_wr(8'h21, 2, 64'hFFFF_FFFF_AABB_CCDD);
        put_wr(8'h27, 1, 64'h0000_0000_0000_EEF0);
        put_rd(8'h20, 3, 0, "R3");

        // R4: byte writes by parity
        put_wr(8'h40, 1, 64'h0001);
        put_rd(8'h40, 0, 1, "R4");
        put_wr(8'h40, 0, 64'hFF);
        put_rd(8'h40, 0, 1, "R4");
        put_wr(8'h43, 0, 64'h01);
        put_rd(8'h42, 0, 1, "R4");
        put_wr(8'h41, 0, 64'h01);
        put_wr(8'h41, 0, 64'hFE);
        put_rd(8'h40, 0, 1, "R4");

        // R5: halfword writes set both bits from bit 0
        put_wr(8'h50, 1, 64'h0003);
        put_wr(8'h52, 1, 64'h0002);
        put_rd(8'h50, 0, 1, "R5");
        put_rd(8'h51, 2, 1, "R5");
        put_wr(8'h53, 1, 64'h0001);
        put_rd(8'h52, 0, 1, "R5");

        // R6: word and doubleword writes keep hidden bits
        put_wr(8'h60, 1, 64'h0001);
        put_wr(8'h60, 2, 64'hFFFF_FFFE);
        put_wr(8'h60, 3, 64'hFFFF_FFFF_FFFF_FFFE);
        put_rd(8'h60, 0, 1, "R6");
        put_rd(8'h60, 3, 0, "R6");

        // R7: window past the last entry, size ignored
        put_wr(CAP - 2, 1, 64'h1);
        put_rd(CAP - 2, 3, 1, "R7");
        put_rd(CAP - 1, 1, 1, "R7");
        put_rd(CAP - 4, 0, 1, "R7");

        // R8: out-of-range accesses
        put_rd(0, 3, 0, "R8");
        put_wr(CAP, 3, 64'hDEAD_BEEF_0BAD_F00D);
        put_wr(CAP + 1, 1, 64'h1);
        put_rd(0, 3, 0, "R8");
        put_rd(0, 0, 1, "R8");
        put_rd(CAP, 3, 0, "R8");
        put_rd(CAP + 5, 0, 1, "R8");

        // R9: same-cycle read and write return old contents
        put_wr(8'h70, 3, 64'h1111_2222_3333_4444);
        cur_req = "R9";
        wr_en = 1'b1; wr_addr = ADDR_W'(8'h70); wr_size = 2'd3; wr_data = 64'h5555_6666_7777_8888;
        rd_en = 1'b1; rd_addr = ADDR_W'(8'h70); rd_size = 2'd3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        put_rd(8'h70, 3, 0, "R9");

        // R2: warm reset keeps contents
        put_wr(8'h88, 3, 64'h0123_4567_89AB_CDEF);
        put_wr(8'h88, 1, 64'h0001);
        cur_req = "R2";
        rst = 1'b1; rd_en = 1'b1; rd_addr = ADDR_W'(8'h88); rd_size = 2'd3;
        wr_en = 1'b1; wr_addr = ADDR_W'(8'h88); wr_size = 2'd3; wr_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        put_rd(8'h88, 3, 0, "R2");
        put_rd(8'h88, 0, 1, "R2");

        // Mixed traffic
        cur_req = "";
        for (int i = 0; i < 400; i++) begin
            wr_en     = 1'($urandom_range(0, 1));
            wr_addr   = ADDR_W'($urandom_range(0, CAP + 63));
            wr_size   = 2'($urandom_range(0, 3));
            wr_data   = {$urandom, $urandom};
            rd_en     = 1'($urandom_range(0, 1));
            rd_addr   = ADDR_W'($urandom_range(0, CAP + 63));
            rd_size   = 2'($urandom_range(0, 3));
            test_mode = ($urandom_range(0, 3) == 0);
            @(negedge clk);
        end
        wr_en = 0; rd_en = 0; test_mode = 0;

        // R1: second cold reset clears everything again
        cold_rst = 1'b1;
        @(negedge clk);
        cold_rst = 1'b0;
        while (clr_busy) @(negedge clk);
        put_rd(8'h88, 3, 0, "R1");
        put_rd(8'h50, 0, 1, "R1");
        put_rd(8'h70, 3, 0, "R1");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule